// File: doc/BRIEF.md
# Activity-Driven Clock Gate for a Pipelined Core

This block saves dynamic power in a small pipelined processor by withholding clock edges from register banks that have nothing to do. It watches three pieces of core state, all on the free-running clock: a halt indication, a flag saying that the instruction in decode is a no-operation, and the current program counter. From these it forms three idle conditions: halted, a long run of no-operations, and a stalled program counter. Each sleepable unit has its own sensitivity mask. The mask picks which of the three conditions may switch that unit's clock off.

Each unit gets a glitch-free gated copy of the global clock, built from a latch that is transparent while the clock is low and an AND gate. The enable is computed from registered history together with the current inputs. An enable change that is presented during the low phase takes effect at the next rising edge. All history registers stay on the ungated clock, so a wake-up request is always seen. The wake-up request comes from an interrupt or a restart. It reopens every clock in its own cycle and clears all history.

The reset input is asynchronous and active low. It is expected to be released in step with the clock.

Top module: `cg_activity_gate`

## Requirements
- R1: While reset is asserted, and directly after it, every unit's enable is 1 and its gated clock follows the global clock. Reset also clears the sticky halt state.
- R2: Each gated clock changes only with the global clock. Every high pulse lasts a full half period. An enable presented while the clock is low controls the next rising edge.
- R3: A cycle with the halt input at 1 suppresses the rising edge that ends that cycle. Suppression continues in later cycles until a wake-up or reset, even after the halt input drops. This applies to every unit whose mask has bit 0 set.
- R4: A cycle with the wake-up input at 1 enables every unit for that edge. It clears the halt state, the no-operation run and the PC-match run. Wake-up wins over a halt in the same cycle.
- R5: A cycle that is the NOP_RUN-th or later consecutive no-operation cycle (default 4) gates units whose mask has bit 1 set. The first cycle without a no-operation re-enables them and restarts the run.
- R6: A cycle that is the STALL_RUN-th or later consecutive cycle (default 3) in which the PC equals the previous cycle's PC gates units whose mask has bit 2 set. The first cycle with a different PC re-enables them. The first cycle after reset never counts as a match.
- R7: Each unit reacts only to the conditions selected by its 3-bit field in UNIT_SENS (bit 0 halt, bit 1 no-op run, bit 2 PC stall). By default unit 0 uses all three, unit 1 uses halt only, and unit 2 uses halt and no-op run.
- R8: unit_en_o presents, during the low phase, the enable value that the following rising edge of that unit's gated clock will obey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running global clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| halt_i | input | 1 | Halt instruction in effect this cycle |
| dec_nop_i | input | 1 | Instruction in decode is a no-operation |
| pc_i | input | PC_W | Current program counter |
| wake_i | input | 1 | Interrupt or restart request |
| unit_en_o | output | NUM_UNITS | Per-unit clock enable before the latch |
| gclk_o | output | NUM_UNITS | Per-unit gated clock |

## Verification
The hardest state to reach is the boundary of each counted run. A wake-up that lands on the exact cycle the no-operation run saturates must be followed by a fresh run. The PC stall must fire only on the third repeated value, never on the second. The vector table therefore sets these cycles up one at a time, with the PC stepping by four between them so that no stall builds up by accident. A wake-up coinciding with a halt is placed on its own cycle, and a reset applied mid-halt is exercised directly. A pulse-width monitor on every gated clock watches the whole run for shortened pulses.

// File: rtl/cg_pkg.sv
package cg_pkg;

  // Number of idle conditions a unit can be sensitive to.
  localparam int unsigned COND_W = 3;

  // Bit 0 halt, bit 1 no-op run, bit 2 PC stall (matches UNIT_SENS fields).
  typedef struct packed {
    logic stall;
    logic nop;
    logic halt;
  } idle_cond_t;

endpackage

// File: rtl/cg_halt_track.sv
module cg_halt_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic wake_i,
  output logic halt_o
);

  logic halt_q;
  logic halt_d;

  always_comb begin
    if (wake_i) halt_d = 1'b0;
    else        halt_d = halt_q | halt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= halt_d;
  end

  assign halt_o = (halt_q | halt_i) & ~wake_i;

  a_r3_halt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wake_i) |=> halt_q);
  a_r3_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !wake_i) |=> halt_q);
  a_r4_wake_clears_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !halt_q);

endmodule

// File: rtl/cg_nop_run.sv
module cg_nop_run #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nop_i,
  input  logic wake_i,
  output logic idle_o
);

  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (wake_i || !nop_i)     cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign idle_o = nop_i & ~wake_i & (cnt_q == CNT_MAX);

  a_r5_run_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nop_i |=> (cnt_q == '0));
  a_r5_run_climbs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nop_i && !wake_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r4_wake_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (cnt_q == '0));

endmodule

// File: rtl/cg_pc_stall.sv
module cg_pc_stall #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned RUN_LEN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  input  logic            wake_i,
  output logic            idle_o
);

  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN - 1);

  logic [PC_W-1:0] prev_q;
  logic            seen_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_d;
  logic            same_pc;

  assign same_pc = seen_q && (pc_i == prev_q);

  always_comb begin
    if (wake_i || !same_pc)    cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= pc_i;
      seen_q <= 1'b1;
      cnt_q  <= cnt_d;
    end
  end

  assign idle_o = same_pc & ~wake_i & (cnt_q == CNT_MAX);

  a_r6_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_i != prev_q) |=> (cnt_q == '0));
  a_r6_tracks_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (prev_q == $past(pc_i)));

endmodule

// File: rtl/cg_clk_gate.sv
module cg_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_q;

  // Transparent while the clock is low: enable is frozen through the high phase.
  always_latch begin
    if (!clk_i) en_q = en_i;
  end

  assign gclk_o = clk_i & en_q;

endmodule

// File: rtl/cg_activity_gate.sv
module cg_activity_gate
  import cg_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned NOP_RUN   = 4,
  parameter int unsigned STALL_RUN = 3,
  parameter int unsigned NUM_UNITS = 3,
  parameter logic [NUM_UNITS*COND_W-1:0] UNIT_SENS = 9'b011_001_111
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_i,
  input  logic                 dec_nop_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic                 wake_i,
  output logic [NUM_UNITS-1:0] unit_en_o,
  output logic [NUM_UNITS-1:0] gclk_o
);

  idle_cond_t cond;

  cg_halt_track u_halt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (halt_i),
    .wake_i (wake_i),
    .halt_o (cond.halt)
  );

  cg_nop_run #(.RUN_LEN(NOP_RUN)) u_nop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nop_i  (dec_nop_i),
    .wake_i (wake_i),
    .idle_o (cond.nop)
  );

  cg_pc_stall #(.PC_W(PC_W), .RUN_LEN(STALL_RUN)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pc_i   (pc_i),
    .wake_i (wake_i),
    .idle_o (cond.stall)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [COND_W-1:0] SENS = UNIT_SENS[u*COND_W +: COND_W];

    assign unit_en_o[u] = !(rst_ni && |(cond & SENS));

    cg_clk_gate u_gate (
      .clk_i  (clk_i),
      .en_i   (unit_en_o[u]),
      .gclk_o (gclk_o[u])
    );

    if (SENS[0]) begin : g_halt_chk
      a_r3_halt_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && !wake_i) |-> !unit_en_o[u]);
    end
  end

  a_r4_wake_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> (&unit_en_o));

endmodule

// File: tb/cg_activity_gate_test.sv
module cg_activity_gate_test;

  localparam int unsigned NU = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          halt_i;
  logic          dec_nop_i;
  logic [31:0]   pc_i;
  logic          wake_i;
  logic [NU-1:0] unit_en_o;
  logic [NU-1:0] gclk_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk_i = ~clk_i;

  cg_activity_gate uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .dec_nop_i (dec_nop_i),
    .pc_i      (pc_i),
    .wake_i    (wake_i),
    .unit_en_o (unit_en_o),
    .gclk_o    (gclk_o)
  );

  // halt, nop, wake, pc[7:0], expected gated edges {unit2,unit1,unit0}
  typedef struct packed {
    logic       halt;
    logic       nop;
    logic       wake;
    logic [7:0] pc;
    logic [2:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    {1'b0,1'b0,1'b0,8'h00,3'b111},  // 0  R6 first cycle no match
    {1'b0,1'b1,1'b0,8'h04,3'b111},  // 1  R5 run 1
    {1'b0,1'b1,1'b0,8'h08,3'b111},  // 2  R5 run 2
    {1'b0,1'b1,1'b0,8'h0C,3'b111},  // 3  R5 run 3
    {1'b0,1'b1,1'b0,8'h10,3'b010},  // 4  R5 run 4 gates, R7 unit1 ignores
    {1'b0,1'b1,1'b0,8'h14,3'b010},  // 5  R5 still gated
    {1'b0,1'b0,1'b0,8'h18,3'b111},  // 6  R5 non-nop resumes
    {1'b0,1'b1,1'b0,8'h1C,3'b111},  // 7  R5 run restarted
    {1'b0,1'b0,1'b0,8'h1C,3'b111},  // 8  R6 match 1
    {1'b0,1'b0,1'b0,8'h1C,3'b111},  // 9  R6 match 2
    {1'b0,1'b0,1'b0,8'h1C,3'b110},  // 10 R6 match 3 gates unit0 only (R7)
    {1'b0,1'b0,1'b0,8'h1C,3'b110},  // 11 R6 still gated
    {1'b0,1'b0,1'b0,8'h20,3'b111},  // 12 R6 PC moves, resumes
    {1'b1,1'b0,1'b0,8'h24,3'b000},  // 13 R3 halt gates all
    {1'b0,1'b0,1'b0,8'h28,3'b000},  // 14 R3 sticky
    {1'b0,1'b1,1'b0,8'h2C,3'b000},  // 15 R3 sticky
    {1'b0,1'b0,1'b1,8'h30,3'b111},  // 16 R4 wake
    {1'b0,1'b0,1'b0,8'h34,3'b111},  // 17 R4 halt cleared
    {1'b1,1'b0,1'b1,8'h38,3'b111},  // 18 R4 wake beats halt
    {1'b0,1'b0,1'b0,8'h3C,3'b111},  // 19 R4 halt not latched
    {1'b0,1'b1,1'b0,8'h40,3'b111},  // 20 R5 run 1
    {1'b0,1'b1,1'b0,8'h44,3'b111},  // 21 R5 run 2
    {1'b0,1'b1,1'b0,8'h48,3'b111},  // 22 R5 run 3
    {1'b0,1'b1,1'b0,8'h4C,3'b010},  // 23 R5 run 4 gates
    {1'b0,1'b1,1'b1,8'h50,3'b111},  // 24 R4 wake clears run
    {1'b0,1'b1,1'b0,8'h54,3'b111},  // 25 R4 run counts from 1
    {1'b0,1'b0,1'b0,8'h58,3'b111}   // 26 R5 plain
  };

  function automatic string req_of(int i);
    if (i == 0 || (i >= 8 && i <= 12)) return "R6";
    if (i >= 13 && i <= 15)            return "R3";
    if (i >= 16 && i <= 19)            return "R4";
    if (i == 24 || i == 25)            return "R4";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2 pulse-width monitor on each gated clock
  int short_cnt [NU];
  int pulse_cnt [NU];
  for (genvar g = 0; g < NU; g++) begin : g_mon
    realtime t_rise;
    bit      risen;
    initial begin
      risen = 1'b0;
      short_cnt[g] = 0;
      pulse_cnt[g] = 0;
    end
    always @(posedge gclk_o[g]) begin
      t_rise = $realtime;
      risen  = 1'b1;
    end
    always @(negedge gclk_o[g]) begin
      if (risen) begin
        pulse_cnt[g]++;
        if ($realtime - t_rise < 4.5) short_cnt[g]++;
      end
    end
  end

  task automatic drive(input logic h, input logic n, input logic w, input logic [31:0] p);
    halt_i    = h;
    dec_nop_i = n;
    wake_i    = w;
    pc_i      = p;
  endtask

  initial begin
    rst_ni = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 32'h0);

    // R1: clocks run during reset even with halt and nop asserted
    @(negedge clk_i); #1;
    chk(unit_en_o == 3'b111, "R1", "enables in reset", unit_en_o, 3'b111);
    @(posedge clk_i); #2;
    chk(gclk_o == 3'b111, "R1", "gated clocks in reset", gclk_o, 3'b111);

    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) @(negedge clk_i);
      #1;
      drive(VECS[i].halt, VECS[i].nop, VECS[i].wake, {24'h0, VECS[i].pc});
      #2;
      chk(unit_en_o == VECS[i].exp, "R8", $sformatf("enable vector %0d", i),
          unit_en_o, VECS[i].exp);
      @(posedge clk_i); #2;
      chk(gclk_o == VECS[i].exp, req_of(i), $sformatf("gated edge vector %0d", i),
          gclk_o, VECS[i].exp);
    end

    // R3 then R1: halt, then reset mid-halt reopens and clears the sticky state
    @(negedge clk_i); #1;
    drive(1'b1, 1'b0, 1'b0, 32'h100);
    @(negedge clk_i); #1;
    drive(1'b0, 1'b0, 1'b0, 32'h104);
    @(posedge clk_i); #2;
    chk(gclk_o == 3'b000, "R3", "halt held after input drops", gclk_o, 3'b000);
    @(negedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    chk(unit_en_o == 3'b111, "R1", "reset reopens enables", unit_en_o, 3'b111);
    @(posedge clk_i); #2;
    chk(gclk_o == 3'b111, "R1", "reset reopens clocks", gclk_o, 3'b111);
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 32'h108);
    @(posedge clk_i); #2;
    chk(gclk_o == 3'b111, "R1", "halt cleared by reset", gclk_o, 3'b111);

    // R6: stall after reset counts from the second cycle, not the first
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); #1;
      drive(1'b0, 1'b0, 1'b0, 32'h108);
      @(posedge clk_i); #2;
      chk(gclk_o == ((k >= 2) ? 3'b110 : 3'b111), "R6",
          $sformatf("stall run step %0d", k), gclk_o, (k >= 2) ? 3'b110 : 3'b111);
    end

    // R2: no shortened pulse and every unit actually pulsed
    for (int g = 0; g < NU; g++) begin
      chk(short_cnt[g] == 0 && pulse_cnt[g] > 0, "R2",
          $sformatf("short pulses unit %0d", g), short_cnt[g], 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule